// File: doc/BRIEF.md
# Per-Bank Fuse Word SECDED Decoder

This block corrects errors in the words read from a set of fuse banks. Each bank stores 20 data bits, five Hamming check bits and one overall parity bit, 26 bits in all. Error correction can be switched on or off for each bank. With correction on, a single flipped bit is repaired and a double flip is reported without repair. Each bank has its own single-error flag, double-error flag and 6-bit syndrome register. Error events also feed one shared sticky interrupt, which has a mask.

The host presents the fuse words, pulses a load request, and then reads the decoded data, the syndromes and the flags. A raw-read control makes the load capture the uncorrected data bits, for example to inspect what was really burned. The syndromes and flags are still updated in that mode. The flags and the interrupt stay set until the host clears them with write-one-to-clear pulses.

Top module: `fuse_ecc_top`

## Requirements
- R1: Each bank word has data d[i] in bits 0..19, check bit c[k] in bit 20+k (k = 0..4), and overall parity in bit 25. Data bit i sits at the i-th Hamming position that is not a power of two (3, 5, 6, 7, 9, ...). c[k] is the even parity of the data bits whose position has bit k set. Bit 25 makes the XOR of all 26 bits zero. The reported syndrome is {position syndrome[4:0], overall parity error}, so an error in data bit 5 gives 0x15.
- R2: For an enabled bank, an odd overall parity with a position syndrome of 0..25 counts as a single error. The load corrects that bit, sets the bank's single-error flag and stores the syndrome.
- R3: For an enabled bank, an even overall parity with a nonzero position syndrome counts as a double error. So does an odd overall parity with a position above 25. The load leaves the data uncorrected, sets the bank's double-error flag and stores the syndrome.
- R4: For a bank whose ecc_en bit is 0, a load passes the raw data bits through, stores a syndrome of 0 and sets no flag.
- R5: With raw_rd at 1 during a load, data_out takes the uncorrected data bits. Syndromes and flags update as in R2 to R4.
- R6: The per-bank flags se_flags[b] and de_flags[b] are sticky. A 1 on clr_se[b] or clr_de[b] clears only that bit. A set from a load in the same cycle wins over the clear.
- R7: irq_pend is set by any load that sets a single or double flag in any bank. It stays set until an irq_clr pulse, and a set wins over a clear.
- R8: The interrupt mask is 1 after reset. mask_wr loads mask_val into it. irq_out is 1 only when irq_pend is 1 and the mask is 0.
- R9: After reset, data_out, syndrome, se_flags, de_flags and irq_pend are all 0.
- R10: Outputs change only on a cycle with load_req at 1, and they show the result one clock later. A change on fuse_bits without a load has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fuse_bits | input | 130 | Bank words, bank b in bits [26b+25:26b] |
| ecc_en | input | 5 | Correction enable per bank |
| raw_rd | input | 1 | Capture uncorrected data on load |
| load_req | input | 1 | Decode all banks and capture results |
| clr_se | input | 5 | Write-one-to-clear for single-error flags |
| clr_de | input | 5 | Write-one-to-clear for double-error flags |
| irq_clr | input | 1 | Clear the sticky interrupt |
| mask_wr | input | 1 | Write strobe for the interrupt mask |
| mask_val | input | 1 | New interrupt mask value |
| data_out | output | 100 | Decoded data, bank b in bits [20b+19:20b] |
| syndrome | output | 30 | Syndrome per bank, bank b in bits [6b+5:6b] |
| se_flags | output | 5 | Sticky single-error flags |
| de_flags | output | 5 | Sticky double-error flags |
| irq_pend | output | 1 | Sticky combined error interrupt |
| irq_out | output | 1 | Interrupt after the mask |

## Verification
A wrong bit-to-position map or a wrong parity tree shows up at the next load. The syndrome register reads a value other than the one R1 predicts, and a corrected data word comes out with a bit still flipped. A flag register that drops its state, or lets one bank's clear reach another, is visible on se_flags or de_flags one cycle after the clear or the clean load. A stuck mask or interrupt state appears on irq_out one cycle after the mask write.

// File: rtl/fuse_ecc_pkg.sv
package fuse_ecc_pkg;

    localparam int DATA_W   = 20;
    localparam int HAM_W    = 5;
    localparam int SYN_W    = HAM_W + 1;
    localparam int WORD_W   = DATA_W + HAM_W + 1;
    localparam int LAST_POS = DATA_W + HAM_W;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [SYN_W-1:0]  syn;
        logic              single;
        logic              dbl;
    } dec_t;

    // Hamming position of data bit idx: the idx-th non power of two from 3 up
    function automatic int data_pos(input int idx);
        int cnt;
        int pos;
        cnt = 0;
        pos = 0;
        for (int p = 1; p <= LAST_POS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx) pos = p;
                cnt++;
            end
        end
        return pos;
    endfunction

endpackage

// File: rtl/fuse_secded_dec.sv
module fuse_secded_dec
    import fuse_ecc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              en,
    output dec_t              res
);

    logic [LAST_POS:1] cw;
    logic [HAM_W-1:0]  hsyn;
    logic              par_err;
    logic              pos_ok;

    always_comb begin
        cw = '0;
        for (int i = 0; i < DATA_W; i++) cw[data_pos(i)] = word[i];
        for (int k = 0; k < HAM_W; k++) cw[1 << k] = word[DATA_W + k];
    end

    always_comb begin
        hsyn = '0;
        for (int p = 1; p <= LAST_POS; p++) begin
            for (int k = 0; k < HAM_W; k++) begin
                if (((p >> k) & 1) == 1) hsyn[k] = hsyn[k] ^ cw[p];
            end
        end
    end

    assign par_err = ^word;
    assign pos_ok  = int'(hsyn) <= LAST_POS;

    always_comb begin
        res = '0;
        for (int i = 0; i < DATA_W; i++) begin
            res.data[i] = word[i];
            if (en && par_err && int'(hsyn) == data_pos(i))
                res.data[i] = ~word[i];
        end
        if (en) begin
            res.syn    = {hsyn, par_err};
            res.single = par_err && pos_ok;
            res.dbl    = (!par_err && hsyn != '0) || (par_err && !pos_ok);
        end
    end

endmodule

// File: rtl/fuse_bank_state.sv
module fuse_bank_state
    import fuse_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              raw_rd,
    input  dec_t              res,
    input  logic [DATA_W-1:0] raw_data,
    input  logic              clr_se,
    input  logic              clr_de,
    output logic [DATA_W-1:0] data_q,
    output logic [SYN_W-1:0]  syn_q,
    output logic              se_q,
    output logic              de_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            syn_q  <= '0;
            se_q   <= 1'b0;
            de_q   <= 1'b0;
        end else begin
            if (load) begin
                data_q <= raw_rd ? raw_data : res.data;
                syn_q  <= res.syn;
            end
            if (load && res.single) se_q <= 1'b1;
            else if (clr_se)        se_q <= 1'b0;
            if (load && res.dbl)    de_q <= 1'b1;
            else if (clr_de)        de_q <= 1'b0;
        end
    end

endmodule

// File: rtl/fuse_ecc_top.sv
module fuse_ecc_top
    import fuse_ecc_pkg::*;
#(
    parameter int NUM_BANKS = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_BANKS*WORD_W-1:0]   fuse_bits,
    input  logic [NUM_BANKS-1:0]          ecc_en,
    input  logic                          raw_rd,
    input  logic                          load_req,
    input  logic [NUM_BANKS-1:0]          clr_se,
    input  logic [NUM_BANKS-1:0]          clr_de,
    input  logic                          irq_clr,
    input  logic                          mask_wr,
    input  logic                          mask_val,
    output logic [NUM_BANKS*DATA_W-1:0]   data_out,
    output logic [NUM_BANKS*SYN_W-1:0]    syndrome,
    output logic [NUM_BANKS-1:0]          se_flags,
    output logic [NUM_BANKS-1:0]          de_flags,
    output logic                          irq_pend,
    output logic                          irq_out
);

    logic [NUM_BANKS-1:0] err_v;
    logic                 mask_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dec_t res;

        fuse_secded_dec u_dec (
            .word (fuse_bits[b*WORD_W +: WORD_W]),
            .en   (ecc_en[b]),
            .res  (res)
        );

        fuse_bank_state u_state (
            .clk      (clk),
            .rst      (rst),
            .load     (load_req),
            .raw_rd   (raw_rd),
            .res      (res),
            .raw_data (fuse_bits[b*WORD_W +: DATA_W]),
            .clr_se   (clr_se[b]),
            .clr_de   (clr_de[b]),
            .data_q   (data_out[b*DATA_W +: DATA_W]),
            .syn_q    (syndrome[b*SYN_W +: SYN_W]),
            .se_q     (se_flags[b]),
            .de_q     (de_flags[b])
        );

        assign err_v[b] = res.single | res.dbl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pend <= 1'b0;
            mask_q   <= 1'b1;
        end else begin
            if (load_req && err_v != '0) irq_pend <= 1'b1;
            else if (irq_clr)            irq_pend <= 1'b0;
            if (mask_wr) mask_q <= mask_val;
        end
    end

    assign irq_out = irq_pend & ~mask_q;

endmodule

// File: rtl/fuse_ecc_checker.sv
module fuse_ecc_checker
    import fuse_ecc_pkg::*;
#(
    parameter int NUM_BANKS = 5
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NUM_BANKS*WORD_W-1:0] fuse_bits,
    input logic [NUM_BANKS-1:0]        ecc_en,
    input logic                        raw_rd,
    input logic                        load_req,
    input logic [NUM_BANKS-1:0]        clr_se,
    input logic [NUM_BANKS-1:0]        clr_de,
    input logic [NUM_BANKS*DATA_W-1:0] data_out,
    input logic [NUM_BANKS*SYN_W-1:0]  syndrome,
    input logic [NUM_BANKS-1:0]        se_flags,
    input logic [NUM_BANKS-1:0]        de_flags,
    input logic                        irq_pend,
    input logic                        irq_out
);

    logic [NUM_BANKS*DATA_W-1:0] raw_v;
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_raw
        assign raw_v[b*DATA_W +: DATA_W] = fuse_bits[b*WORD_W +: DATA_W];
    end

    // R6: a flag that is not cleared keeps its value
    a_r6_se_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((se_flags & $past(se_flags & ~clr_se)) == $past(se_flags & ~clr_se)));
    a_r6_de_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((de_flags & $past(de_flags & ~clr_de)) == $past(de_flags & ~clr_de)));

    // R10: no new flag without a load
    a_r10_no_set_idle: assert property (@(posedge clk) disable iff (rst)
        !load_req |=> (((se_flags | de_flags) & ~$past(se_flags | de_flags)) == '0));

    // R7: a newly raised flag comes with the pending interrupt
    a_r7_irq_follows: assert property (@(posedge clk) disable iff (rst)
        (((se_flags | de_flags) & ~$past(se_flags | de_flags)) != '0) |-> irq_pend);

    // R5: raw read captures the uncorrected data
    a_r5_raw_capture: assert property (@(posedge clk) disable iff (rst)
        (load_req && raw_rd) |=> (data_out == $past(raw_v)));

    // R4: with all banks disabled data passes and syndromes read zero
    a_r4_all_bypass: assert property (@(posedge clk) disable iff (rst)
        (load_req && ecc_en == '0) |=> (syndrome == '0 && data_out == $past(raw_v)));

    // R8: no interrupt output without a pending interrupt
    a_r8_out_needs_pend: assert property (@(posedge clk) disable iff (rst)
        !irq_pend |-> !irq_out);

endmodule

bind fuse_ecc_top fuse_ecc_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk(clk), .rst(rst), .fuse_bits(fuse_bits), .ecc_en(ecc_en),
    .raw_rd(raw_rd), .load_req(load_req), .clr_se(clr_se), .clr_de(clr_de),
    .data_out(data_out), .syndrome(syndrome), .se_flags(se_flags),
    .de_flags(de_flags), .irq_pend(irq_pend), .irq_out(irq_out)
);

// File: tb/fuse_ecc_top_test.sv
`timescale 1ns/1ps
module fuse_ecc_top_test;

    localparam int NB = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NB*26-1:0] fuse_bits = '0;
    logic [NB-1:0]   ecc_en = '1;
    logic            raw_rd = 1'b0;
    logic            load_req = 1'b0;
    logic [NB-1:0]   clr_se = '0;
    logic [NB-1:0]   clr_de = '0;
    logic            irq_clr = 1'b0;
    logic            mask_wr = 1'b0;
    logic            mask_val = 1'b1;
    logic [NB*20-1:0] data_out;
    logic [NB*6-1:0] syndrome;
    logic [NB-1:0]   se_flags, de_flags;
    logic            irq_pend, irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fuse_ecc_top uut (
        .clk(clk), .rst(rst), .fuse_bits(fuse_bits), .ecc_en(ecc_en),
        .raw_rd(raw_rd), .load_req(load_req), .clr_se(clr_se), .clr_de(clr_de),
        .irq_clr(irq_clr), .mask_wr(mask_wr), .mask_val(mask_val),
        .data_out(data_out), .syndrome(syndrome), .se_flags(se_flags),
        .de_flags(de_flags), .irq_pend(irq_pend), .irq_out(irq_out)
    );

    localparam int POS [20] = '{3, 5, 6, 7, 9, 10, 11, 12, 13, 14,
                                15, 17, 18, 19, 20, 21, 22, 23, 24, 25};

    function automatic logic [25:0] enc(input logic [19:0] d);
        logic [25:0] w;
        w = '0;
        w[19:0] = d;
        for (int k = 0; k < 5; k++)
            for (int i = 0; i < 20; i++)
                if (((POS[i] >> k) & 1) == 1) w[20+k] = w[20+k] ^ d[i];
        w[25] = ^w[24:0];
        return w;
    endfunction

    function automatic logic [25:0] flip(input logic [25:0] w, input logic [4:0] a,
                                         input logic [4:0] b);
        logic [25:0] r;
        r = w;
        if (a != 5'd31) r[a] = ~r[a];
        if (b != 5'd31) r[b] = ~r[b];
        return r;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_load;
        @(negedge clk) load_req = 1'b1;
        @(negedge clk) load_req = 1'b0;
    endtask

    task automatic clear_all;
        @(negedge clk) begin clr_se = '1; clr_de = '1; irq_clr = 1'b1; end
        @(negedge clk) begin clr_se = '0; clr_de = '0; irq_clr = 1'b0; end
    endtask

    task automatic clean_banks;
        for (int b = 0; b < NB; b++) fuse_bits[b*26 +: 26] = enc(20'h0A0A0 + 20'(b));
    endtask

    typedef struct packed {
        logic [19:0] data;
        logic [4:0]  fa;
        logic [4:0]  fb;
        logic        en;
        logic        se;
        logic        de;
        logic [5:0]  syn;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{20'hA5C3E, 5'd31, 5'd31, 1'b1, 1'b0, 1'b0, 6'h00},
        '{20'h12345, 5'd5,  5'd31, 1'b1, 1'b1, 1'b0, 6'h15},
        '{20'h0F0F0, 5'd0,  5'd31, 1'b1, 1'b1, 1'b0, 6'h07},
        '{20'hFFFFF, 5'd19, 5'd31, 1'b1, 1'b1, 1'b0, 6'h33},
        '{20'h55555, 5'd25, 5'd31, 1'b1, 1'b1, 1'b0, 6'h01},
        '{20'h00000, 5'd22, 5'd31, 1'b1, 1'b1, 1'b0, 6'h09},
        '{20'h0001F, 5'd20, 5'd31, 1'b1, 1'b1, 1'b0, 6'h03},
        '{20'h3C3C3, 5'd0,  5'd1,  1'b1, 1'b0, 1'b1, 6'h0C},
        '{20'hABCDE, 5'd5,  5'd19, 1'b1, 1'b0, 1'b1, 6'h26},
        '{20'h13579, 5'd20, 5'd25, 1'b1, 1'b0, 1'b1, 6'h02},
        '{20'h12345, 5'd5,  5'd31, 1'b0, 1'b0, 1'b0, 6'h00}
    };

    initial begin
        #200000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [25:0] w;
        logic [19:0] exp_d;
        logic [19:0] hold;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 data", 128'(data_out), 0);
        chk("R9 syn", 128'(syndrome), 0);
        chk("R9 flags", 128'({se_flags, de_flags, irq_pend}), 0);
        chk("R8 irq_out reset", 128'(irq_out), 0);

        // Table walk on bank 2 (R1 R2 R3 R4)
        for (int v = 0; v < 11; v++) begin
            clean_banks();
            ecc_en = '1;
            ecc_en[2] = VECS[v].en;
            w = flip(enc(VECS[v].data), VECS[v].fa, VECS[v].fb);
            fuse_bits[2*26 +: 26] = w;
            clear_all();
            do_load();
            exp_d = (VECS[v].se) ? VECS[v].data : w[19:0];
            chk("R2/R3/R4 data", 128'(data_out[2*20 +: 20]), 128'(exp_d));
            chk("R1 syndrome", 128'(syndrome[2*6 +: 6]), 128'(VECS[v].syn));
            chk("R2 se_flags", 128'(se_flags), 128'({VECS[v].se, 2'b00}));
            chk("R3 de_flags", 128'(de_flags), 128'({VECS[v].de, 2'b00}));
            chk("R7 irq_pend", 128'(irq_pend), 128'(VECS[v].se | VECS[v].de));
            chk("R4 clean bank", 128'(data_out[0 +: 20]), 128'(20'h0A0A0));
        end

        // R8 mask defaults to 1, then unmask
        clean_banks();
        ecc_en = '1;
        clear_all();
        fuse_bits[0 +: 26] = flip(enc(20'h0A0A0), 5'd3, 5'd31);
        do_load();
        chk("R7 pend on error", 128'(irq_pend), 1);
        chk("R8 masked out", 128'(irq_out), 0);
        @(negedge clk) begin mask_wr = 1'b1; mask_val = 1'b0; end
        @(negedge clk) mask_wr = 1'b0;
        chk("R8 unmasked out", 128'(irq_out), 1);

        // R6 sticky across clean load, clear only own bit
        clean_banks();
        do_load();
        chk("R6 sticky after clean load", 128'(se_flags), 1);
        chk("R10 corrected data", 128'(data_out[0 +: 20]), 128'(20'h0A0A0));
        @(negedge clk) clr_se = 5'b00010;
        @(negedge clk) clr_se = '0;
        chk("R6 other bit clear", 128'(se_flags), 1);
        @(negedge clk) clr_se = 5'b00001;
        @(negedge clk) clr_se = '0;
        chk("R6 own bit clear", 128'(se_flags), 0);
        chk("R7 pend sticky", 128'(irq_pend), 1);
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        chk("R7 pend cleared", 128'(irq_pend), 0);
        chk("R8 out follows pend", 128'(irq_out), 0);

        // R6 and R7 set wins over clear
        fuse_bits[0 +: 26] = flip(enc(20'h0A0A0), 5'd7, 5'd31);
        @(negedge clk) begin load_req = 1'b1; clr_se = '1; irq_clr = 1'b1; end
        @(negedge clk) begin load_req = 1'b0; clr_se = '0; irq_clr = 1'b0; end
        chk("R6 set wins", 128'(se_flags), 1);
        chk("R7 set wins", 128'(irq_pend), 1);

        // R5 raw read still flags
        clean_banks();
        clear_all();
        w = flip(enc(20'h0A0A3), 5'd5, 5'd31);
        fuse_bits[3*26 +: 26] = w;
        raw_rd = 1'b1;
        do_load();
        raw_rd = 1'b0;
        chk("R5 raw data", 128'(data_out[3*20 +: 20]), 128'(w[19:0]));
        chk("R5 raw flags", 128'(se_flags), 128'(5'b01000));
        chk("R5 raw syndrome", 128'(syndrome[3*6 +: 6]), 128'(6'h15));

        // R10 no effect without load
        hold = data_out[3*20 +: 20];
        fuse_bits[3*26 +: 26] = enc(20'hFFFFF);
        repeat (3) @(negedge clk);
        chk("R10 no load data", 128'(data_out[3*20 +: 20]), 128'(hold));
        chk("R10 no load syn", 128'(syndrome[3*6 +: 6]), 128'(6'h15));

        // R2 R3 two banks at once
        clean_banks();
        clear_all();
        fuse_bits[0 +: 26] = flip(enc(20'h0A0A0), 5'd10, 5'd31);
        fuse_bits[4*26 +: 26] = flip(enc(20'h0A0A4), 5'd2, 5'd9);
        do_load();
        chk("R2 multi se", 128'(se_flags), 128'(5'b00001));
        chk("R3 multi de", 128'(de_flags), 128'(5'b10000));
        chk("R3 multi data", 128'(data_out[4*20 +: 20]),
            128'(20'h0A0A4 ^ 20'h00204));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule